// File: doc/BRIEF.md
# Single-Channel PWM Generator with Deferred Reconfiguration

The block generates one pulse-width-modulated output from a fast input clock. A prescaler turns the input clock into counter steps. A period counter then counts steps from zero up to one less than the programmed modulus and wraps. The output is high while the count is below the programmed duty value. This gives a high time of (PRESCALE + 1) × DUTY input cycles and a period of (PRESCALE + 1) × MOD input cycles.

Software reaches four word-aligned registers through a simple write strobe and read strobe. Any address with a nonzero byte offset is ignored. Writes to the prescale and modulus registers are only staged. A write to the duty register marks the staged set as pending. The pending set is handed to the running timebase at the next period boundary, so the output never shows a partial mix of old and new settings. It also never cuts a running period short. While the channel is disabled, a pending set is taken over at once.

Software must therefore write DUTY last.

Top module: `pwm_shadow_chan`

## Requirements
- R1: After reset the output is low and all four registers read back zero.
- R2: Registers sit at byte addresses 0x0 (prescale), 0x4 (modulus), 0x8 (duty) and 0xC (enable, bit 0). A read returns the last value written, zero-extended on the 32-bit read bus, one cycle after the read strobe.
- R3: The duty register keeps only its low 8 bits. Bits 31..8 of any read are zero.
- R4: For 1 ≤ DUTY < MOD, each period is high for (PRESCALE+1)×DUTY cycles and then low for (PRESCALE+1)×(MOD−DUTY) cycles.
- R5: Writing only the prescale or modulus register leaves the output waveform unchanged.
- R6: A duty write takes effect at the next period boundary. The period running at the time of the write completes with its old high and low times.
- R7: When DUTY ≥ MOD (with DUTY > 0) the output stays high. When DUTY = 0 it stays low.
- R8: While enable is 0, the output is low within two cycles of the write and the counters are held at zero. Settings committed while disabled apply from the first period after enabling, and that first period is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the timebase source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| pwm_out | output | 1 | PWM output, normal polarity |

## Verification
The sharpest case is a reconfiguration issued in the middle of a long high phase. A design that applied the new values immediately would show a truncated pulse or a shortened low phase in that period. A design that committed on a prescale or modulus write would change the measured high and low times even though no duty write occurred.

The duty extremes are also probed. These are duty equal to or above the modulus, and duty of zero. An off-by-one compare or wrap would produce a one-step glitch there instead of a flat level.

The bench also checks the first period after enabling. A design that failed to hold its counters while disabled would start mid-period and give a short first pulse.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    REG_PSC  = 2'd0,
    REG_MOD  = 2'd1,
    REG_DUTY = 2'd2,
    REG_EN   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int BUS_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BUS_W-1:0]    wdata,
  input  logic                commit,
  output logic [BUS_W-1:0]    rdata,
  output logic [CNT_W-1:0]    psc_sh,
  output logic [CNT_W-1:0]    mod_sh,
  output logic [CNT_W-1:0]    duty_sh,
  output logic                en_q,
  output logic                pend_q
);

  localparam int PAD_W = BUS_W - CNT_W;

  reg_sel_e         sel;
  logic             hit;
  logic             wr_psc, wr_mod, wr_duty, wr_en_reg;
  logic [CNT_W-1:0] psc_d, mod_d, duty_d;
  logic             en_d, pend_d;
  logic [BUS_W-1:0] rd_val, rdata_d;
  logic             unused_hi;

  assign unused_hi = ^wdata[BUS_W-1:CNT_W];

  // address decode: only word-aligned addresses hit
  always_comb begin
    hit       = (addr[1:0] == 2'b00);
    sel       = reg_sel_e'(addr[3:2]);
    wr_psc    = wr_en && hit && (sel == REG_PSC);
    wr_mod    = wr_en && hit && (sel == REG_MOD);
    wr_duty   = wr_en && hit && (sel == REG_DUTY);
    wr_en_reg = wr_en && hit && (sel == REG_EN);
  end

  // next-state of staged registers
  always_comb begin
    psc_d  = wr_psc    ? wdata[CNT_W-1:0] : psc_sh;
    mod_d  = wr_mod    ? wdata[CNT_W-1:0] : mod_sh;
    duty_d = wr_duty   ? wdata[CNT_W-1:0] : duty_sh;
    en_d   = wr_en_reg ? wdata[0]         : en_q;
    // a new duty write wins over a commit in the same cycle
    if (wr_duty)     pend_d = 1'b1;
    else if (commit) pend_d = 1'b0;
    else             pend_d = pend_q;
  end

  // readback mux
  always_comb begin
    rd_val = '0;
    if (hit) begin
      unique case (sel)
        REG_PSC:  rd_val = {{PAD_W{1'b0}}, psc_sh};
        REG_MOD:  rd_val = {{PAD_W{1'b0}}, mod_sh};
        REG_DUTY: rd_val = {{PAD_W{1'b0}}, duty_sh};
        REG_EN:   rd_val = {{(BUS_W-1){1'b0}}, en_q};
        default:  rd_val = '0;
      endcase
    end
    rdata_d = rd_en ? rd_val : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_sh  <= '0;
      mod_sh  <= '0;
      duty_sh <= '0;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      rdata   <= '0;
    end else begin
      psc_sh  <= psc_d;
      mod_sh  <= mod_d;
      duty_sh <= duty_d;
      en_q    <= en_d;
      pend_q  <= pend_d;
      rdata   <= rdata_d;
    end
  end

endmodule

// File: rtl/pwm_chan_timebase.sv
module pwm_chan_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pend,
  input  logic [CNT_W-1:0] psc_sh,
  input  logic [CNT_W-1:0] mod_sh,
  input  logic [CNT_W-1:0] duty_sh,
  output logic             commit,
  output logic [CNT_W-1:0] pre_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] act_psc,
  output logic [CNT_W-1:0] act_mod,
  output logic [CNT_W-1:0] act_duty
);

  localparam int EXT_W = CNT_W + 1;

  logic             step_tick, last_step, boundary;
  logic [EXT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] pre_d, cnt_d;
  logic [CNT_W-1:0] act_psc_d, act_mod_d, act_duty_d;

  always_comb begin
    step_tick = (pre_q == act_psc);
    cnt_inc   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    // a modulus of zero behaves as a single-step period
    last_step = (cnt_inc >= {1'b0, act_mod});
    boundary  = step_tick && last_step;
    commit    = pend && (!en || boundary);
  end

  // counter next-state
  always_comb begin
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (!en || boundary) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (step_tick) begin
      pre_d = '0;
      cnt_d = cnt_inc[CNT_W-1:0];
    end else begin
      pre_d = pre_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  // active configuration is only reloaded on a commit
  always_comb begin
    act_psc_d  = commit ? psc_sh  : act_psc;
    act_mod_d  = commit ? mod_sh  : act_mod;
    act_duty_d = commit ? duty_sh : act_duty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      cnt_q    <= '0;
      act_psc  <= '0;
      act_mod  <= '0;
      act_duty <= '0;
    end else begin
      pre_q    <= pre_d;
      cnt_q    <= cnt_d;
      act_psc  <= act_psc_d;
      act_mod  <= act_mod_d;
      act_duty <= act_duty_d;
    end
  end

endmodule

// File: rtl/pwm_chan_compare.sv
module pwm_chan_compare #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm_q
);

  logic pwm_d;

  always_comb begin
    pwm_d = en && (cnt < duty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int BUS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              pwm_out
);

  logic [CNT_W-1:0] psc_sh, mod_sh, duty_sh;
  logic [CNT_W-1:0] act_psc, act_mod, act_duty;
  logic [CNT_W-1:0] pre_q, cnt_q;
  logic             en_q, pend_q, commit;

  pwm_chan_regs #(
    .CNT_W (CNT_W),
    .BUS_W (BUS_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .commit  (commit),
    .rdata   (rdata),
    .psc_sh  (psc_sh),
    .mod_sh  (mod_sh),
    .duty_sh (duty_sh),
    .en_q    (en_q),
    .pend_q  (pend_q)
  );

  pwm_chan_timebase #(
    .CNT_W (CNT_W)
  ) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_q),
    .pend     (pend_q),
    .psc_sh   (psc_sh),
    .mod_sh   (mod_sh),
    .duty_sh  (duty_sh),
    .commit   (commit),
    .pre_q    (pre_q),
    .cnt_q    (cnt_q),
    .act_psc  (act_psc),
    .act_mod  (act_mod),
    .act_duty (act_duty)
  );

  pwm_chan_compare #(
    .CNT_W (CNT_W)
  ) u_cmp (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_q),
    .cnt   (cnt_q),
    .duty  (act_duty),
    .pwm_q (pwm_out)
  );

endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int CNT_W = 8,
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             pend_q,
  input logic [CNT_W-1:0] pre_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] act_mod,
  input logic [CNT_W-1:0] act_duty,
  input logic             pwm_out,
  input logic [BUS_W-1:0] rdata
);

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[BUS_W-1:CNT_W] == '0); // R3

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && act_mod != '0) |-> (cnt_q < act_mod)); // R4

  AST_NO_SILENT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_mod) || !$stable(act_duty)) |-> $past(pend_q)); // R5

  AST_COMMIT_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_mod) || !$stable(act_duty)) |-> (cnt_q == '0 && pre_q == '0)); // R6

  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_q) && $past(act_duty >= act_mod) && $past(act_duty != '0)) |-> pwm_out); // R7

  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act_duty == '0) |-> !pwm_out); // R7

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !pwm_out); // R8

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (cnt_q == '0 && pre_q == '0)); // R8

endmodule

bind pwm_shadow_chan pwm_chan_chk #(
  .CNT_W (CNT_W),
  .BUS_W (BUS_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_q     (en_q),
  .pend_q   (pend_q),
  .pre_q    (pre_q),
  .cnt_q    (cnt_q),
  .act_mod  (act_mod),
  .act_duty (act_duty),
  .pwm_out  (pwm_out),
  .rdata    (rdata)
);

// File: tb/sim_pwm_shadow_chan.sv
module sim_pwm_shadow_chan;

  localparam int CLK_P = 10;
  localparam int WAIT_LIM = 6000;

  logic        clk;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        pwm_out;

  int total, bad;
  int rise_cnt, fall_cnt, hi_len, lo_len, run_len;
  logic prev_out;

  pwm_shadow_chan u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pwm_out (pwm_out)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // run-length monitor sampled away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_out = 1'b0;
      run_len  = 0;
    end else begin
      if (pwm_out == prev_out) run_len++;
      else begin
        if (prev_out) begin hi_len = run_len; fall_cnt++; end
        else          begin lo_len = run_len; rise_cnt++; end
        run_len = 1;
      end
      prev_out = pwm_out;
    end
  end

  function automatic int exp_high(int p, int d);
    return (p + 1) * d;
  endfunction

  function automatic int exp_low(int p, int m, int d);
    return (p + 1) * (m - d);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic cfg(input int p, input int m, input int d);
    wr(4'h0, p);
    wr(4'h4, m);
    wr(4'h8, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rises(input int n, output bit ok);
    int r0 = rise_cnt;
    int t = 0;
    while (rise_cnt < r0 + n && t < WAIT_LIM) begin @(posedge clk); t++; end
    ok = (rise_cnt >= r0 + n);
  endtask

  task automatic wait_falls(input int n, output bit ok);
    int f0 = fall_cnt;
    int t = 0;
    while (fall_cnt < f0 + n && t < WAIT_LIM) begin @(posedge clk); t++; end
    ok = (fall_cnt >= f0 + n);
  endtask

  // skip a possibly stale period, then take one full high/low pair
  task automatic measure(input string req, input int p, input int m, input int d);
    bit ok;
    wait_rises(3, ok);
    chk({req, " timeout"}, int'(ok), 1);
    chk({req, " high"}, hi_len, exp_high(p, d));
    chk({req, " low"}, lo_len, exp_low(p, m, d));
  endtask

  task automatic steady(input string req, input logic lvl, input int n);
    int miss = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out !== lvl) miss++;
    end
    chk(req, miss, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit ok;
    int p, m, d;
    total = 0; bad = 0;
    rise_cnt = 0; fall_cnt = 0; hi_len = 0; lo_len = 0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    void'($urandom(32'd7321));
    idle(4);
    chk("R1 out in reset", int'(pwm_out), 0);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    rd(4'h0, v); chk("R1 psc", v, 0);
    rd(4'h4, v); chk("R1 mod", v, 0);
    rd(4'h8, v); chk("R1 duty", v, 0);
    rd(4'hC, v); chk("R1 en", v, 0);
    chk("R1 out after reset", int'(pwm_out), 0);

    // R2 / R3 readback
    wr(4'h0, 32'h0000_005A); rd(4'h0, v); chk("R2 psc readback", v, 32'h5A);
    wr(4'h4, 32'h0000_00C3); rd(4'h4, v); chk("R2 mod readback", v, 32'hC3);
    wr(4'h8, 32'hFFFF_FF3C); rd(4'h8, v); chk("R3 duty masked", v, 32'h3C);
    wr(4'hC, 32'h0000_0003); rd(4'hC, v); chk("R2 en readback", v, 1);
    wr(4'hC, 32'h0); rd(4'hC, v); chk("R2 en cleared", v, 0);
    wr(4'h6, 32'h11); rd(4'h4, v); chk("R2 misaligned ignored", v, 32'hC3);

    // R8 config while disabled, first period complete
    cfg(1, 10, 4);
    wr(4'hC, 32'h1);
    wait_falls(1, ok);
    chk("R8 first high timeout", int'(ok), 1);
    chk("R8 first high", hi_len, exp_high(1, 4));
    // R4 directed
    measure("R4 p1 m10 d4", 1, 10, 4);
    cfg(0, 2, 1);
    measure("R4 p0 m2 d1", 0, 2, 1);

    // R4 constrained random
    for (int k = 0; k < 8; k++) begin
      p = int'($urandom_range(5, 0));
      m = int'($urandom_range(31, 2));
      d = int'($urandom_range(m - 1, 1));
      cfg(p, m, d);
      measure("R4 random", p, m, d);
    end

    // R5 staged writes without duty leave the waveform alone
    cfg(2, 12, 5);
    measure("R5 base", 2, 12, 5);
    wr(4'h0, 32'h4);
    wr(4'h4, 32'h20);
    measure("R5 no duty write", 2, 12, 5);
    wr(4'h8, 32'h9);
    measure("R6 duty write commits", 4, 32, 9);

    // R6 mid-period rewrite does not shorten the running period
    cfg(3, 40, 20);
    measure("R6 base", 3, 40, 20);
    wait_rises(1, ok);
    cfg(0, 10, 5);
    wait_falls(1, ok);
    chk("R6 old high kept", hi_len, exp_high(3, 20));
    wait_rises(1, ok);
    chk("R6 old low kept", lo_len, exp_low(3, 40, 20));
    measure("R6 new setting", 0, 10, 5);

    // R7 extremes
    cfg(2, 6, 6);
    idle(100);
    steady("R7 duty eq mod high", 1'b1, 200);
    wr(4'h8, 32'hC8);
    idle(100);
    steady("R7 duty above mod high", 1'b1, 200);
    wr(4'h8, 32'h0);
    idle(100);
    steady("R7 duty zero low", 1'b0, 200);

    // R8 disable
    cfg(1, 10, 4);
    measure("R8 before disable", 1, 10, 4);
    wr(4'hC, 32'h0);
    idle(1);
    steady("R8 disabled low", 1'b0, 150);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule